// File: doc/BRIEF.md
# Prefix-OR Priority Arbiter

This block picks a single winner from a vector of request lines. The lowest-numbered asserted line wins. Bit 0 has the highest priority, and priority falls as the index rises. The winner is not found with a chain of priority-encoder stages. Instead, a logarithmic-depth parallel prefix network builds, for each position, the OR of every request below it. That "diminished" OR is inverted and masked with the requests, which leaves exactly the first set bit standing.

The one-hot grant and a flag saying that a grant exists are both registered. A request vector presented before a rising clock edge is therefore answered on the outputs right after that edge. The block is meant to sit in front of a shared resource that several agents contend for, in places where a fixed priority is acceptable and the combinational depth must grow only with log2 of the width.

Top module: `prefix_or_arbiter`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a clock edge, both the grant vector and the valid flag read 0 after that edge.
- R2: The outputs change only at a rising clock edge. After an edge they reflect the request vector sampled at that edge, so there is one cycle of latency.
- R3: The grant vector never has more than one bit set.
- R4: When any request is set, the grant bit that is set is at the lowest index among the set request bits. Bit 0 has the highest priority.
- R5: When the sampled request vector is all zeros, the grant vector is all zeros and the valid flag is 0.
- R6: The valid flag is 1 exactly when the grant vector is non-zero, which is exactly when the sampled request vector is non-zero.
- R7: A grant bit is never set for a position whose request bit was 0 when it was sampled.
- R8: With 11 lines and requests at indices 2, 4, 7, 8 and 9 (vector 11'h394), the grant is index 2 only (11'h004).
- R9: When only the top index (N-1) requests, that index is granted. When every line requests, index 0 is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N | Request lines; bit i is agent i |
| grant_o | output | N | Registered one-hot (or zero) grant |
| grant_vld_o | output | 1 | Registered flag; high when a grant is issued |

## Verification
The input that is hardest to reach is a request set whose lowest bit sits far from index 0 while many higher bits are also set. Only that kind of input needs the wide spans of the upper prefix levels to suppress the higher requests. Walking a single bit through every position does not exercise those spans. The stimulus therefore adds, for each position, a pattern made of that bit plus every bit above it. It also runs a long stream of pseudo-random vectors from a shift-register generator, and places reset in the middle of traffic.

// File: rtl/pfx_arb_pkg.sv
package pfx_arb_pkg;

  // Number of doubling stages needed to span a vector of n bits.
  function automatic int unsigned span_stages(input int unsigned n);
    int unsigned s;
    s = 0;
    while ((1 << s) < n) s++;
    return s;
  endfunction

endpackage

// File: rtl/pfx_or_net.sv
// Inclusive prefix OR built from log2(N) doubling stages.
module pfx_or_net
  import pfx_arb_pkg::*;
#(
  parameter int unsigned N = 11
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] incl_o
);

  localparam int unsigned LV = span_stages(N);

  logic [N-1:0] stage [0:LV];

  assign stage[0] = vec_i;

  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    localparam int unsigned DIST = 1 << lv;
    for (genvar b = 0; b < N; b++) begin : g_bit
      if (b >= DIST) begin : g_comb
        assign stage[lv+1][b] = stage[lv][b] | stage[lv][b-DIST];
      end else begin : g_pass
        assign stage[lv+1][b] = stage[lv][b];
      end
    end
  end

  assign incl_o = stage[LV];

endmodule

// File: rtl/arb_grant_form.sv
// Shift the inclusive prefix by one place (diminished form), invert, and mask.
module arb_grant_form #(
  parameter int unsigned N = 11
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] incl_i,
  output logic [N-1:0] win_o,
  output logic         any_o
);

  logic [N-1:0] below;

  assign below[0] = 1'b0;
  for (genvar b = 1; b < N; b++) begin : g_dim
    assign below[b] = incl_i[b-1];
  end

  assign win_o = req_i & ~below;
  assign any_o = incl_i[N-1];

endmodule

// File: rtl/prefix_or_arbiter.sv
module prefix_or_arbiter #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         grant_vld_o
);

  logic [N-1:0] incl;
  logic [N-1:0] win;
  logic         any;

  pfx_or_net #(.N(N)) u_net (
    .vec_i  (req_i),
    .incl_o (incl)
  );

  arb_grant_form #(.N(N)) u_form (
    .req_i  (req_i),
    .incl_i (incl),
    .win_o  (win),
    .any_o  (any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o     <= '0;
      grant_vld_o <= 1'b0;
    end else begin
      grant_o     <= win;
      grant_vld_o <= any;
    end
  end

endmodule

// File: rtl/prefix_or_arbiter_chk.sv
module prefix_or_arbiter_chk #(
  parameter int unsigned N = 11
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req_i,
  input logic [N-1:0] grant_o,
  input logic         grant_vld_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (grant_o == '0 && !grant_vld_o));

  // R3
  one_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R6
  valid_match_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld_o == (grant_o != '0));

  // R2
  latency_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i != '0) |=> grant_vld_o);

  // R5
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0) |=> (grant_o == '0 && !grant_vld_o));

  // R7
  subset_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((grant_o & ~$past(req_i)) == '0));

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (grant_o == '0 || (((grant_o - 1'b1) & $past(req_i)) == '0)));

endmodule

bind prefix_or_arbiter prefix_or_arbiter_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .grant_o     (grant_o),
  .grant_vld_o (grant_vld_o)
);

// File: tb/tb_prefix_or_arbiter.sv
`timescale 1ns/1ps
module tb_prefix_or_arbiter;

  localparam int unsigned N = 11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] grant_o;
  logic         grant_vld_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prefix_or_arbiter #(.N(N)) dut (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .grant_o     (grant_o),
    .grant_vld_o (grant_vld_o)
  );

  function automatic logic [N-1:0] model_grant(input logic [N-1:0] r);
    logic [N-1:0] g;
    g = '0;
    for (int k = 0; k < N; k++) begin
      if (r[k]) begin
        g[k] = 1'b1;
        break;
      end
    end
    return g;
  endfunction

  task automatic expect_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply a request vector, let one edge pass, check at the falling edge.
  task automatic apply(input logic [N-1:0] r, input string tag);
    logic [N-1:0] prev_g;
    logic [N-1:0] exp_g;
    prev_g = grant_o;
    req_i = r;
    #1;
    expect_vec({"R2 hold-before-edge ", tag}, grant_o, prev_g);
    @(negedge clk);
    exp_g = model_grant(r);
    expect_vec({"R4 grant ", tag}, grant_o, exp_g);
    expect_vec({"R6 valid ", tag}, {{(N-1){1'b0}}, grant_vld_o}, {{(N-1){1'b0}}, (r != '0)});
    expect_vec({"R3 onehot ", tag}, N'($countones(grant_o) > 1), '0);
    expect_vec({"R7 subset ", tag}, grant_o & ~r, '0);
  endtask

  initial begin
    logic [N-1:0] lfsr;
    @(negedge clk);
    req_i = '1;
    @(negedge clk);
    @(negedge clk);
    // R1: reset held with active requests
    expect_vec("R1 reset grant", grant_o, '0);
    expect_vec("R1 reset valid", {{(N-1){1'b0}}, grant_vld_o}, '0);
    rst = 1'b0;
    req_i = '0;
    @(negedge clk);

    // R8 worked example
    apply(11'h394, "R8 example");
    expect_vec("R8 example grant", grant_o, 11'h004);
    // R5 idle
    apply('0, "R5 idle");
    expect_vec("R5 idle valid", {{(N-1){1'b0}}, grant_vld_o}, '0);
    // R9 top index alone and all set
    apply(N'(1) << (N-1), "R9 top only");
    expect_vec("R9 top grant", grant_o, N'(1) << (N-1));
    apply('1, "R9 all set");
    expect_vec("R9 all grant", grant_o, N'(1));

    // Walk single bits and bit-plus-everything-above
    for (int p = 0; p < N; p++) begin
      apply(N'(1) << p, "R4 walk");
      apply(~((N'(1) << p) - N'(1)), "R4 upper-fill");
    end

    // R1: reset asserted mid-traffic
    req_i = 11'h0F0;
    rst = 1'b1;
    @(negedge clk);
    expect_vec("R1 mid reset grant", grant_o, '0);
    expect_vec("R1 mid reset valid", {{(N-1){1'b0}}, grant_vld_o}, '0);
    rst = 1'b0;
    @(negedge clk);
    expect_vec("R2 after reset release", grant_o, 11'h010);

    // Pseudo-random stream
    lfsr = 11'h2A5;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[N-2:0], lfsr[10] ^ lfsr[8]};
      apply((n % 7 == 0) ? (lfsr & (lfsr << 3)) : lfsr, "R4 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule